// File: doc/BRIEF.md
# Page-Buffered Memory Write Engine

This engine sits behind a two-wire serial slave. It gathers the data bytes of a single write session into a one-page staging buffer. When the session closes, it copies the staged bytes into a byte-wide storage array. The slave loads a starting location when the address phase ends. It then hands over each data byte with a one-cycle strobe and pulses a stop input when the bus STOP condition is seen. The engine reports each byte it takes on a registered acknowledge. While it copies the page into the array, it raises busy for a fixed, programmable number of clocks. During that window the slave refuses new requests.

A page is 64 bytes. The location splits into a page number in the upper bits and a 6-bit byte offset in the lower bits. Only the offset advances from byte to byte, so a long burst folds back onto the start of the same page. A write-protect level blocks all staging. The array comes out of reset erased, with every byte at 0xFF. A registered read port lets the slave fetch stored bytes. By default the array holds 2048 bytes. The address width parameter scales it up to the full 32768-byte organisation of 512 pages.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, busy_o and byte_ack_o are low, and every array location reads 0xFF.
- R2: A load pulse while idle takes start_addr_i. Bits [ADDR_W-1:6] select the page, bits [5:0] select the starting byte offset, and all staged bytes are discarded.
- R3: A data strobe accepted while idle with write protect low is stored at the current offset. The offset then advances by one modulo 64 and the page stays fixed. byte_ack_o is high for exactly the following cycle.
- R4: After offset 63 the offset returns to 0. A later byte sent to an offset replaces the earlier one, and the commit never touches the next page.
- R5: No staged byte reaches the array before the stop pulse. Reads in the meantime return the previous contents.
- R6: A stop pulse while idle with at least one staged byte starts a commit. busy_o rises in the next cycle and stays high for exactly COMMIT_CYC cycles.
- R7: A commit writes only the offsets that received a byte in the session, each once. All other bytes of the page keep their values.
- R8: While wp_i is high, data strobes are neither acknowledged nor staged, and a following stop starts no commit.
- R9: A stop with no staged byte (address-only write) leaves busy_o low.
- R10: While busy_o is high, stop, load and data strobes are ignored. Data strobes get no acknowledge, and the busy window is neither lengthened nor restarted.
- R11: rd_data_o shows the byte at rd_addr_i one clock after the address is presented.
- R12: mem_we_o is asserted only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_load_i | input | 1 | Strobe: take start_addr_i as the session start |
| start_addr_i | input | ADDR_W | Session starting location |
| wdata_valid_i | input | 1 | Strobe: one data byte is present |
| wdata_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Pulse on bus STOP |
| wp_i | input | 1 | Write-protect level, high blocks writes |
| byte_ack_o | output | 1 | Previous-cycle data byte was accepted |
| busy_o | output | 1 | Commit window active |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write location |
| mem_wdata_o | output | DATA_W | Array write byte |
| rd_addr_i | input | ADDR_W | Read location |
| rd_data_o | output | DATA_W | Read byte, registered |

## Verification
A corrupted offset counter shows up only after the next commit, as bytes stored one place off or spilled across a page boundary. It is therefore caught by reading back whole pages, including the folded burst and the untouched neighbouring page. A stale byte mask shows at the ports in two ways. The commit's write-enable pulse count differs from the number of distinct offsets sent, and a byte that was never sent turns up in a readback. A timer fault changes the measured busy length or lets a second stop stretch it, and it is visible within one commit window.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  localparam int unsigned OFF_W      = 6;
  localparam int unsigned PAGE_BYTES = 1 << OFF_W;
endpackage

// File: rtl/pcw_page_buffer.sv
module pcw_page_buffer #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned OFF_W = pcw_pkg::OFF_W,
  localparam int unsigned PG_W  = ADDR_W - OFF_W,
  localparam int unsigned NB    = pcw_pkg::PAGE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic [OFF_W-1:0]  sel_i,
  output logic [PG_W-1:0]   page_o,
  output logic              any_o,
  output logic              sel_valid_o,
  output logic [DATA_W-1:0] sel_data_o
);
  logic [OFF_W-1:0]  off_q;
  logic [NB-1:0]     mask_q;
  logic [DATA_W-1:0] stage_q [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      off_q  <= '0;
      mask_q <= '0;
    end else if (clr_i) begin
      mask_q <= '0;
    end else if (load_i) begin
      page_o <= addr_i[ADDR_W-1:OFF_W];
      off_q  <= addr_i[OFF_W-1:0];
      mask_q <= '0;
    end else if (wr_i) begin
      mask_q[off_q] <= 1'b1;
      off_q         <= off_q + 1'b1; // wraps inside the page
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !load_i && !clr_i) stage_q[off_q] <= wdata_i;
  end

  assign any_o       = |mask_q;
  assign sel_valid_o = mask_q[sel_i];
  assign sel_data_o  = stage_q[sel_i];
endmodule

// File: rtl/pcw_commit_timer.sv
module pcw_commit_timer #(
  parameter int unsigned COMMIT_CYC = 625000,
  localparam int unsigned OFF_W = pcw_pkg::OFF_W,
  localparam int unsigned CNT_W = $clog2(COMMIT_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             in_page_o,
  output logic [OFF_W-1:0] idx_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o    = busy_o && (cnt_q == CNT_W'(COMMIT_CYC - 1));
  assign in_page_o = busy_o && (cnt_q < CNT_W'(pcw_pkg::PAGE_BYTES));
  assign idx_o     = cnt_q[OFF_W-1:0];
endmodule

// File: rtl/pcw_store.sv
module pcw_store #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cell_q [DEPTH];
  logic [DEPTH-1:0]  filled_q; // clear = erased, reads as all ones

  always_ff @(posedge clk_i) begin
    if (we_i) cell_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filled_q <= '0;
      rdata_o  <= '1;
    end else begin
      if (we_i) filled_q[waddr_i] <= 1'b1;
      rdata_o <= filled_q[raddr_i] ? cell_q[raddr_i] : '1;
    end
  end
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine #(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned COMMIT_CYC = 625000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              wdata_valid_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              byte_ack_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned OFF_W = pcw_pkg::OFF_W;
  localparam int unsigned PG_W  = ADDR_W - OFF_W;

  logic             accept, load, start, done, in_page, any, sel_valid;
  logic [OFF_W-1:0] idx;
  logic [PG_W-1:0]  page;

  assign load   = addr_load_i && !busy_o;
  assign accept = wdata_valid_i && !wp_i && !busy_o;
  assign start  = stop_i && any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byte_ack_o <= 1'b0;
    else         byte_ack_o <= accept && !load;
  end

  pcw_page_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .load_i(load), .addr_i(start_addr_i),
    .wr_i(accept), .wdata_i,
    .clr_i(done), .sel_i(idx),
    .page_o(page), .any_o(any),
    .sel_valid_o(sel_valid), .sel_data_o(mem_wdata_o)
  );

  pcw_commit_timer #(.COMMIT_CYC(COMMIT_CYC)) u_tmr (
    .clk_i, .rst_ni,
    .start_i(start), .busy_o,
    .done_o(done), .in_page_o(in_page), .idx_o(idx)
  );

  assign mem_we_o   = in_page && sel_valid;
  assign mem_addr_o = {page, idx};

  pcw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni,
    .we_i(mem_we_o), .waddr_i(mem_addr_o), .wdata_i(mem_wdata_o),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/pcw_checker.sv
module pcw_checker #(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned COMMIT_CYC = 625000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_load_i,
  input logic              wdata_valid_i,
  input logic              stop_i,
  input logic              wp_i,
  input logic              byte_ack_o,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  logic [31:0] busy_len_q;
  logic        staged_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len_q <= '0;
    else if (busy_o) busy_len_q <= busy_len_q + 1;
    else             busy_len_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      staged_q <= 1'b0;
    else if (busy_o)                  staged_q <= 1'b0;
    else if (addr_load_i)             staged_q <= 1'b0;
    else if (byte_ack_o)              staged_q <= 1'b1;
  end

  // R6: window length
  assert_busy_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_len_q == COMMIT_CYC);

  // R6: stop with staged data starts commit
  assert_commit_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !busy_o && staged_q |=> busy_o);

  // R9: empty stop
  assert_empty_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !busy_o && !staged_q && !byte_ack_o |=> !busy_o);

  // R8: protected bytes not acknowledged
  assert_wp_nack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i && wdata_valid_i |=> !byte_ack_o);

  // R10: no ack for bytes offered during busy
  assert_busy_nack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && wdata_valid_i |=> !byte_ack_o);

  // R3: ack only follows a strobe
  assert_ack_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ack_o |-> $past(wdata_valid_i));

  // R12: array writes only inside the window
  assert_we_in_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  // R4: one commit stays on one page
  assert_page_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mem_addr_o[ADDR_W-1:pcw_pkg::OFF_W]));
endmodule

bind page_commit_engine pcw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COMMIT_CYC(COMMIT_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_load_i(addr_load_i),
  .wdata_valid_i(wdata_valid_i), .stop_i(stop_i), .wp_i(wp_i),
  .byte_ack_o(byte_ack_o), .busy_o(busy_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o)
);

// File: tb/sim_page_commit_engine.sv
`timescale 1ns/1ps
module sim_page_commit_engine;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int CC = 80;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          addr_load_i = 0, wdata_valid_i = 0, stop_i = 0, wp_i = 0;
  logic [AW-1:0] start_addr_i = '0, rd_addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          byte_ack_o, busy_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, rd_data_o;

  always #4 clk_i = ~clk_i;

  page_commit_engine #(.ADDR_W(AW), .DATA_W(DW), .COMMIT_CYC(CC)) u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] ref_mem [DEPTH];
  logic [AW-7:0] m_page;
  logic [5:0]    m_off;
  logic [63:0]   m_mask;
  logic [7:0]    m_buf [64];

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_req = 0, rd_req_q = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor
  always @(posedge clk_i) rd_req_q <= rd_req;
  always @(negedge clk_i) begin
    if (rd_req_q && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rd_data_o, e);
    end
  end

  // driver side
  task automatic rd(logic [AW-1:0] a, string tag);
    @(negedge clk_i);
    rd_addr_i = a;
    exp_q.push_back(ref_mem[a]);
    tag_q.push_back(tag);
    rd_req = 1;
    @(negedge clk_i);
    rd_req = 0;
  endtask

  task automatic load(logic [AW-1:0] a);
    @(negedge clk_i);
    start_addr_i = a; addr_load_i = 1;
    @(negedge clk_i);
    addr_load_i = 0;
    m_page = a[AW-1:6]; m_off = a[5:0]; m_mask = '0;
  endtask

  task automatic send(logic [7:0] d, bit exp_ack, string tag);
    @(negedge clk_i);
    wdata_i = d; wdata_valid_i = 1;
    @(negedge clk_i);
    wdata_valid_i = 0;
    check(tag, byte_ack_o, exp_ack);
    if (exp_ack) begin
      m_buf[m_off] = d; m_mask[m_off] = 1'b1; m_off = m_off + 1;
    end
  endtask

  task automatic stop_wait(bit exp_commit, bit disturb, string tag);
    int n, we;
    bit low;
    @(negedge clk_i);
    stop_i = 1;
    @(negedge clk_i);
    stop_i = 0;
    if (exp_commit) begin
      n = 0; we = 0;
      while (busy_o && n < CC + 20) begin
        if (mem_we_o) we++;
        if (disturb && n == 10) begin
          stop_i = 1; wdata_valid_i = 1; wdata_i = 8'h99;
          addr_load_i = 1; start_addr_i = '0;
        end else begin
          stop_i = 0; wdata_valid_i = 0; addr_load_i = 0;
        end
        if (disturb && n == 11) check({tag, " R10 ack during busy"}, byte_ack_o, 0);
        n++;
        @(negedge clk_i);
      end
      stop_i = 0; wdata_valid_i = 0; addr_load_i = 0;
      check({tag, " R6 busy length"}, n, CC);
      check({tag, " R7 write count"}, we, $countones(m_mask));
    end
    low = 1;
    for (int i = 0; i < 6; i++) begin
      if (busy_o) low = 0;
      @(negedge clk_i);
    end
    check({tag, " busy low after"}, low, 1);
    if (exp_commit) begin
      for (int k = 0; k < 64; k++)
        if (m_mask[k]) ref_mem[{m_page, 6'(k)}] = m_buf[k];
      m_mask = '0;
    end
  endtask

  // R12 observed at the ports throughout
  int we_bad = 0;
  always @(negedge clk_i) if (rst_ni && mem_we_o && !busy_o) we_bad++;

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    m_mask = '0; m_page = '0; m_off = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 busy", busy_o, 0);
    check("R1 ack", byte_ack_o, 0);
    rd(11'h000, "R1 erased 0");
    rd(11'h7FF, "R1 erased top");
    rd(11'h2BC, "R1 erased mid");

    // single byte write, R2 R3 R5 R11
    load(11'h0A5);
    send(8'h3C, 1, "R3 ack single");
    rd(11'h0A5, "R5 before stop");
    stop_wait(1, 0, "single");
    rd(11'h0A5, "R2 R11 single byte");
    rd(11'h0A4, "R7 neighbour below");
    rd(11'h0A6, "R7 neighbour above");

    // short page write
    load(11'h0C0);
    for (int i = 0; i < 5; i++) send(8'(8'h10 + i), 1, "R3 ack page");
    stop_wait(1, 0, "page5");
    for (int i = 0; i < 7; i++) rd(11'(11'h0C0 + i), "R3 page write");

    // wrap inside page, R4
    load(11'h13E);
    for (int i = 0; i < 66; i++) send(8'(8'h40 + i), 1, "R3 ack burst");
    stop_wait(1, 0, "wrap");
    rd(11'h13E, "R4 overwrite 62");
    rd(11'h13F, "R4 overwrite 63");
    rd(11'h100, "R4 wrapped 0");
    rd(11'h13D, "R4 wrapped 61");
    rd(11'h140, "R4 next page untouched");

    // partial overwrite, R7
    load(11'h0C1);
    send(8'hA1, 1, "R3 ack partial");
    send(8'hA2, 1, "R3 ack partial");
    stop_wait(1, 0, "partial");
    for (int i = 0; i < 5; i++) rd(11'(11'h0C0 + i), "R7 partial keep");

    // write protect, R8
    wp_i = 1;
    load(11'h200);
    for (int i = 0; i < 3; i++) send(8'h55, 0, "R8 no ack");
    stop_wait(0, 0, "R8 wp");
    wp_i = 0;
    rd(11'h200, "R8 unchanged");
    rd(11'h201, "R8 unchanged");

    // address-only, R9
    load(11'h300);
    stop_wait(0, 0, "R9 addr only");

    // disturbance during busy, R10
    load(11'h400);
    send(8'h77, 1, "R3 ack pre-busy");
    stop_wait(1, 1, "R10 disturb");
    rd(11'h400, "R10 committed byte");
    rd(11'h401, "R10 ignored byte");
    rd(11'h000, "R10 ignored load");

    repeat (4) @(negedge clk_i);
    check("R12 we outside busy", we_bad, 0);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule